// File: doc/BRIEF.md
# LPC Memory-Cycle Target Controller

This block is the target side of a Low Pin Count bus. It serves single-byte memory read and memory write cycles for a byte-wide storage array that sits behind a simple synchronous memory port. It watches the frame strobe and the 4-bit multiplexed data bus. When it sees a valid start, it decodes the cycle type and collects the address. It answers only when the device-select field of that address matches its four ID straps.

For a read, the block fetches the byte from the array while the host turns the bus around. It then drives a ready handshake, the data byte (low nibble first), and a one-clock high nibble, and releases the bus. For a write, it collects the byte, pulses the array write strobe once, and returns the same handshake and turnaround. A mode strap set high puts the block in parallel-programming mode, and the bus state machine is then held idle. Whenever the host pulls the frame strobe low, the current cycle is abandoned.

Top module: `lpc_mem_target`

## Requirements
- R1: While rst_ni is low, lad_oe_o, mem_rd_o and mem_we_o are 0, and standby_o is 1 if lframe_ni is high.
- R2: The start code is the lad_i nibble sampled on the last rising edge at which lframe_ni is low. Only a start code of 4'h0 begins a cycle; any other value makes the block ignore the cycle.
- R3: The nibble on the first clock after the frame strobe rises is the cycle type. 4'h4 is a memory read and 4'h6 is a memory write. Any other value is ignored: the block does not drive the bus and issues no strobe.
- R4: The address arrives as eight nibbles, most significant first. mem_addr_o carries address bits [18:0] while a strobe is issued.
- R5: The block responds only when address bits [25:22] equal id_strap_i. On a mismatch it drives nothing and issues no strobe.
- R6: After the address of a matched read, mem_rd_o pulses for exactly one clock. The host then has two turnaround clocks. The block then drives, one per clock, 4'h0, the data low nibble, the data high nibble and 4'hF, then releases the bus. The data is the byte the array returns for that address.
- R7: For a matched write, the byte is taken low nibble first on the two clocks after the address. mem_we_o pulses exactly once with the address and byte. After two turnaround clocks the block drives 4'h0 and then 4'hF, then releases the bus.
- R8: lframe_ni sampled low at any point aborts the current cycle, and lad_oe_o is 0 after that edge.
- R9: While mode_pp_i is high, the bus is never driven and no strobe is issued.
- R10: standby_o is 1 exactly when lframe_ni is high and no cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising-edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_pp_i | input | 1 | Mode strap, high selects parallel-programming mode |
| id_strap_i | input | 4 | Device-select strap value |
| lframe_ni | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | Bus nibble from the host |
| lad_o | output | 4 | Bus nibble driven by the block |
| lad_oe_o | output | 1 | Bus output enable |
| standby_o | output | 1 | Idle indication |
| mem_addr_o | output | 19 | Array byte address |
| mem_rd_o | output | 1 | Array read strobe, data returned on the next clock |
| mem_rdata_i | input | 8 | Array read data |
| mem_wdata_o | output | 8 | Array write data |
| mem_we_o | output | 1 | Array write strobe |

## Verification
Reads and writes are issued in turn at low and high array addresses, and each read follows a write to the same location. This shows that the nibble order, the address order and the round trip through the array all agree. Cycles that carry a foreign ID, a wrong cycle type, a non-zero start code, or a start code changed during a multi-clock frame test the two filters: one rejects a cycle outright, the other lets it through. Aborts in the address phase and in the driven phase, and a run with the mode strap set, check that a cycle is dropped and that the bus is released on the next clock.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_WDATA, ST_TAR_IN, ST_SYNC, ST_RDATA, ST_TAR_OUT
  } lpc_state_e;

  localparam logic [3:0] START_MEM  = 4'h0;
  localparam logic [3:0] CT_MEM_RD  = 4'h4;
  localparam logic [3:0] CT_MEM_WR  = 4'h6;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] LAD_HIGH   = 4'hF;
endpackage

// File: rtl/lpc_addr_collect.sv
module lpc_addr_collect #(
  parameter int ID_LSB = 22,
  parameter int MEM_AW = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [3:0]        nib_i,
  input  logic [3:0]        id_strap_i,
  output logic [MEM_AW-1:0] addr_o,
  output logic              id_hit_o
);
  localparam int HOLD_W = ID_LSB;

  logic [HOLD_W-1:0] addr_q;
  logic [HOLD_W+3:0] addr_nxt;

  // keep only bits below the ID field; the ID is judged on the incoming nibble
  assign addr_nxt = {addr_q, nib_i};
  assign id_hit_o = (addr_nxt[HOLD_W +: 4] == id_strap_i);
  assign addr_o   = addr_q[MEM_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (shift_i) addr_q <= addr_nxt[HOLD_W-1:0];
  end
endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
  import lpc_tgt_pkg::*;
(
  input  lpc_state_e  state_i,
  input  logic        phase_i,
  input  logic [7:0]  rdata_i,
  output logic [3:0]  lad_o,
  output logic        lad_oe_o
);
  always_comb begin
    lad_o    = LAD_HIGH;
    lad_oe_o = 1'b0;
    unique case (state_i)
      ST_SYNC: begin
        lad_o    = SYNC_READY;
        lad_oe_o = 1'b1;
      end
      ST_RDATA: begin
        lad_o    = phase_i ? rdata_i[7:4] : rdata_i[3:0];
        lad_oe_o = 1'b1;
      end
      ST_TAR_OUT: lad_oe_o = ~phase_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_NIB = 8,
  parameter int MEM_AW   = 19,
  parameter int ID_LSB   = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_pp_i,
  input  logic [3:0]        id_strap_i,
  input  logic              lframe_ni,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic              standby_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o
);
  localparam int CNT_W = (ADDR_NIB > 2) ? $clog2(ADDR_NIB) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIB - 1);

  lpc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic [3:0]       start_q;
  logic [7:0]       wdata_q;
  logic [7:0]       rdata_q;
  logic             id_hit;
  logic             addr_shift;

  assign addr_shift = !mode_pp_i && lframe_ni && (state_q == ST_ADDR);

  lpc_addr_collect #(.ID_LSB(ID_LSB), .MEM_AW(MEM_AW)) i_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (addr_shift),
    .nib_i      (lad_i),
    .id_strap_i (id_strap_i),
    .addr_o     (mem_addr_o),
    .id_hit_o   (id_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      start_q <= LAD_HIGH;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (mode_pp_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (!lframe_ni) begin
      // frame low: abort anything, keep latest nibble as start code
      state_q <= ST_START;
      start_q <= lad_i;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_START: begin
          cnt_q <= '0;
          if (start_q == START_MEM && (lad_i == CT_MEM_RD || lad_i == CT_MEM_WR)) begin
            state_q <= ST_ADDR;
            wr_q    <= (lad_i == CT_MEM_WR);
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ADDR: begin
          if (cnt_q == ADDR_LAST) begin
            cnt_q <= '0;
            if (!id_hit)   state_q <= ST_IDLE;
            else if (wr_q) state_q <= ST_WDATA;
            else           state_q <= ST_TAR_IN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WDATA: begin
          if (!cnt_q[0]) begin
            wdata_q[3:0] <= lad_i;
            cnt_q        <= CNT_W'(1);
          end else begin
            wdata_q[7:4] <= lad_i;
            cnt_q        <= '0;
            state_q      <= ST_TAR_IN;
          end
        end
        ST_TAR_IN: begin
          if (!cnt_q[0]) begin
            cnt_q <= CNT_W'(1);
          end else begin
            cnt_q   <= '0;
            state_q <= ST_SYNC;
            if (!wr_q) rdata_q <= mem_rdata_i;
          end
        end
        ST_SYNC: begin
          cnt_q   <= '0;
          state_q <= wr_q ? ST_TAR_OUT : ST_RDATA;
        end
        ST_RDATA: begin
          if (!cnt_q[0]) cnt_q <= CNT_W'(1);
          else begin
            cnt_q   <= '0;
            state_q <= ST_TAR_OUT;
          end
        end
        ST_TAR_OUT: begin
          if (!cnt_q[0]) cnt_q <= CNT_W'(1);
          else begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // array strobes fire in the first host turnaround clock
  assign mem_rd_o    = (state_q == ST_TAR_IN) && (cnt_q == '0) && !wr_q;
  assign mem_we_o    = (state_q == ST_TAR_IN) && (cnt_q == '0) && wr_q;
  assign mem_wdata_o = wdata_q;
  assign standby_o   = lframe_ni && (state_q == ST_IDLE);

  lpc_lad_drive i_drive (
    .state_i  (state_q),
    .phase_i  (cnt_q[0]),
    .rdata_i  (rdata_q),
    .lad_o    (lad_o),
    .lad_oe_o (lad_oe_o)
  );

  // R8
  abort_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_ni |=> !lad_oe_o);
  // R9
  pp_mode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_pp_i |=> (!lad_oe_o && !mem_rd_o && !mem_we_o));
  // R6
  sync_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> (lad_o == SYNC_READY));
  // R6
  rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  // R7
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
endmodule

// File: tb/test_lpc_mem_target.sv
module test_lpc_mem_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_pp = 1'b0;
  logic [3:0]  id_strap = 4'hA;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        standby;
  logic [18:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;

  int vecs = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  lpc_mem_target i_lpc_mem_target (
    .clk_i(clk), .rst_ni(rst_n), .mode_pp_i(mode_pp), .id_strap_i(id_strap),
    .lframe_ni(lframe_n), .lad_i(lad_in), .lad_o(lad_out), .lad_oe_o(lad_oe),
    .standby_o(standby), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we)
  );

  // array model: 256 bytes indexed by low address bits
  logic [7:0] bmem [256];
  logic [7:0] shadow [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bmem[i] <= 8'(i) ^ 8'h5A;
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= bmem[mem_addr[7:0]];
    end
  end

  // observation state
  int          seq_n, we_n, rd_n;
  logic [31:0] seq_v;
  logic [18:0] we_addr, rd_addr;
  logic [7:0]  we_data;

  task automatic clr_obs();
    seq_n = 0; we_n = 0; rd_n = 0; seq_v = '0;
    we_addr = '0; rd_addr = '0; we_data = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (lad_oe) begin seq_n++; seq_v = {seq_v[27:0], lad_out}; end
    if (mem_we) begin we_n++; we_addr = mem_addr; we_data = mem_wdata; end
    if (mem_rd) begin rd_n++; rd_addr = mem_addr; end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input int pre_n, input logic [3:0] pre_nib, input logic [3:0] st,
                           input logic [3:0] ct, input logic [31:0] a, input logic [7:0] wd,
                           input bit is_wr, input bit exp_resp, input string tag);
    logic [31:0] exp_seq;
    clr_obs();
    for (int i = 0; i < pre_n; i++) begin lframe_n = 1'b0; lad_in = pre_nib; tick(); end
    lframe_n = 1'b0; lad_in = st; tick();
    lframe_n = 1'b1; lad_in = ct; tick();
    for (int i = 0; i < 8; i++) begin lad_in = a[31-4*i -: 4]; tick(); end
    for (int k = 0; k < 12; k++) begin
      lad_in = (is_wr && k == 0) ? wd[3:0] : (is_wr && k == 1) ? wd[7:4] : 4'hF;
      tick();
    end
    if (exp_resp && !is_wr) begin
      exp_seq = {20'h0, 4'h0, shadow[a[7:0]][3:0], shadow[a[7:0]][7:4], 4'hF};
      chk(seq_n == 4 && seq_v == exp_seq, {tag, " R6 read nibbles"}, seq_v, exp_seq);
      chk(rd_n == 1 && rd_addr == a[18:0], {tag, " R4 R6 read strobe/addr"},
          {rd_n[7:0], 5'h0, rd_addr}, {8'h1, 5'h0, a[18:0]});
    end else if (exp_resp) begin
      chk(seq_n == 2 && seq_v == 32'h0F, {tag, " R7 write handshake"}, seq_v, 32'h0F);
      chk(we_n == 1 && we_addr == a[18:0] && we_data == wd, {tag, " R4 R7 write strobe"},
          {we_n[3:0], we_data, 1'b0, we_addr}, {4'h1, wd, 1'b0, a[18:0]});
      shadow[a[7:0]] = wd;
    end else begin
      chk(seq_n == 0 && we_n == 0 && rd_n == 0, {tag, " no response"},
          {seq_n[7:0], we_n[7:0], rd_n[7:0], 8'h0}, 32'h0);
    end
  endtask

  function automatic logic [31:0] mk_addr(input logic [3:0] id, input logic [18:0] lo);
    return {6'b0, id, 3'b0, lo};
  endfunction

  // {wr, id, addr[18:0], data, respond}
  localparam int NV = 8;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 4'hA, 19'h00012, 8'h3C, 1'b1},
    {1'b0, 4'hA, 19'h00012, 8'h00, 1'b1},
    {1'b1, 4'hA, 19'h7FF80, 8'hC3, 1'b1},
    {1'b0, 4'hA, 19'h7FF80, 8'h00, 1'b1},
    {1'b1, 4'h5, 19'h00012, 8'hFF, 1'b0},
    {1'b0, 4'hA, 19'h00012, 8'h00, 1'b1},
    {1'b0, 4'h5, 19'h00040, 8'h00, 1'b0},
    {1'b0, 4'hA, 19'h00001, 8'h00, 1'b1}
  };

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, R10 standby
    chk(!lad_oe, "R1 oe in reset", 32'(lad_oe), 0);
    chk(!mem_rd && !mem_we, "R1 strobes in reset", {30'h0, mem_rd, mem_we}, 0);
    chk(standby, "R1 R10 standby in reset", 32'(standby), 1);
    rst_n = 1'b1;
    tick(); tick();

    // main table
    for (int v = 0; v < NV; v++) begin
      logic [32:0] e;
      e = VEC[v];
      bus_cycle(0, 4'h0, 4'h0, e[32] ? 4'h6 : 4'h4, mk_addr(e[31:28], e[27:9]), e[8:1],
                e[32], e[0], e[0] ? "R5 table" : "R5 id mismatch");
    end

    // R2 multi-clock frame: last nibble counts
    bus_cycle(2, 4'hF, 4'h0, 4'h4, mk_addr(4'hA, 19'h00012), 8'h00, 1'b0, 1'b1, "R2 last start");
    bus_cycle(2, 4'h0, 4'h5, 4'h4, mk_addr(4'hA, 19'h00012), 8'h00, 1'b0, 1'b0, "R2 bad start");
    // R3 other cycle types
    bus_cycle(0, 4'h0, 4'h0, 4'h0, mk_addr(4'hA, 19'h00012), 8'h00, 1'b0, 1'b0, "R3 io read");
    bus_cycle(0, 4'h0, 4'h0, 4'h2, mk_addr(4'hA, 19'h00012), 8'h77, 1'b1, 1'b0, "R3 io write");
    // R9 mode strap
    mode_pp = 1'b1;
    bus_cycle(0, 4'h0, 4'h0, 4'h4, mk_addr(4'hA, 19'h00012), 8'h00, 1'b0, 1'b0, "R9 pp read");
    bus_cycle(0, 4'h0, 4'h0, 4'h6, mk_addr(4'hA, 19'h00033), 8'h99, 1'b1, 1'b0, "R9 pp write");
    mode_pp = 1'b0;
    tick();

    // R10 standby follows frame strobe
    lframe_n = 1'b0; #1;
    chk(!standby, "R10 standby with frame low", 32'(standby), 0);
    lframe_n = 1'b1; lad_in = 4'hF; tick(); tick();

    // R8 abort in address phase
    clr_obs();
    lframe_n = 1'b0; lad_in = 4'h0; tick();
    lframe_n = 1'b1; lad_in = 4'h4; tick();
    for (int i = 0; i < 3; i++) begin lad_in = 4'h0; tick(); end
    lframe_n = 1'b0; lad_in = 4'hF; tick();
    chk(!lad_oe, "R8 oe after address abort", 32'(lad_oe), 0);
    lframe_n = 1'b1;
    for (int i = 0; i < 12; i++) tick();
    chk(seq_n == 0 && rd_n == 0, "R8 address abort silent", {seq_n[15:0], rd_n[15:0]}, 0);

    // R8 abort while driving SYNC
    clr_obs();
    lframe_n = 1'b0; lad_in = 4'h0; tick();
    lframe_n = 1'b1; lad_in = 4'h4; tick();
    for (int i = 0; i < 8; i++) begin lad_in = mk_addr(4'hA, 19'h00012)[31-4*i -: 4]; tick(); end
    lad_in = 4'hF; tick(); tick();
    chk(lad_oe && lad_out == 4'h0, "R6 sync driven before abort", {27'h0, lad_oe, lad_out}, 32'h10);
    chk(!standby, "R10 busy during cycle", 32'(standby), 0);
    lframe_n = 1'b0; tick();
    chk(!lad_oe, "R8 oe after sync abort", 32'(lad_oe), 0);
    lframe_n = 1'b1;
    clr_obs();
    for (int i = 0; i < 8; i++) tick();
    chk(seq_n == 0, "R8 no drive after abort", 32'(seq_n), 0);
    chk(standby, "R10 standby after abort", 32'(standby), 1);

    // recovery after abort
    bus_cycle(0, 4'h0, 4'h0, 4'h4, mk_addr(4'hA, 19'h7FF80), 8'h00, 1'b0, 1'b1, "R8 recovery");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule